// File: doc/BRIEF.md
# Zero-Skipping Carry-Save Array Multiplier

This block multiplies two unsigned N-bit operands in a single combinational pass and returns the full 2N-bit product. The partial products go through a carry-save array of adding cells, one row for each multiplier bit above bit 0. A separate carry-propagate adder then resolves the last row's sum and carry vectors into the upper half of the product. The lower half of the product comes straight from the rightmost sum bit of each row.

To cut switching activity, an adding cell is skipped when its partial product is known to be zero. A skipped cell forwards its sum input unchanged and drives its carry output to 0. A parameter sets the zero key:
- the multiplier bit of the cell's row;
- the multiplicand bit of the cell's column;
- either of the two.

A cell whose carry-in can be nonzero has a guard that blocks the skip while that carry-in is 1. Without it an incoming carry would be lost. A second parameter picks the final adder: ripple-carry, group carry-lookahead, or sectioned carry-select. An output map reports which adding cells are skipped for the present operands.

Top module: `bypass_array_mult`

## Requirements
- R1: For every zero-key mode and every final-adder choice, `product` equals `mcand * mplier` exactly.
- R2: In row mode (MODE=BYP_ROW), bit (j-1)*N+i of `bypassMap` (the cell for multiplier bit j in 1..N-1 and multiplicand bit i in 0..N-1) may be 1 only when mplier[j] is 0.
- R3: In column mode (MODE=BYP_COL), map bit (j-1)*N+i may be 1 only when mcand[i] is 0.
- R4: In combined mode (MODE=BYP_BOTH), map bit (j-1)*N+i may be 1 only when mcand[i] is 0 or mplier[j] is 0.
- R5: The first array row (map bits 0..N-1, j=1) has no carry-in, so each of its bits is 1 exactly when that cell's zero key for the selected mode holds.
- R6: In row or combined mode, an mplier of 0 sets every bit of `bypassMap`.
- R7: In column or combined mode, an mcand of 0 sets every bit of `bypassMap`.
- R8: With both operands all ones, no bit of `bypassMap` is set, in any mode.
- R9: Widths N=4, 8 and 16 produce exact products, including zero, all-ones and single-bit operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand | input | N | Unsigned multiplicand |
| mplier | input | N | Unsigned multiplier |
| product | output | 2N | Unsigned product |
| bypassMap | output | N*(N-1) | One bit per adding cell, set while that cell is skipped |

## Verification
The bench builds nine N=4 copies, one for each pairing of zero-key mode and final adder. All nine are swept over all 256 operand pairs, which covers every carry pattern that the skip guard must handle. Three N=8 copies, each with a different mode and adder, go through all 65,536 operand pairs. At that width, carries ripple through several skipped columns. Three N=16 copies are driven with walking single-bit pairs, zero, all-ones and random operands. At that width, the lookahead and select sections span several groups.

// File: rtl/bam_pkg.sv
package bam_pkg;

  // Zero key that allows an adding cell to be skipped.
  typedef enum logic [1:0] {
    BYP_ROW  = 2'd0,
    BYP_COL  = 2'd1,
    BYP_BOTH = 2'd2
  } bypassMode_e;

  // Carry-propagate stage after the array.
  typedef enum logic [1:0] {
    FIN_RIPPLE    = 2'd0,
    FIN_LOOKAHEAD = 2'd1,
    FIN_SELECT    = 2'd2
  } finalAdder_e;

  // Strobes from the control to the array.
  typedef struct packed {
    logic rowEn;
    logic colEn;
  } bypassStrobe_t;

endpackage

// File: rtl/bam_bypass_ctrl.sv
module bam_bypass_ctrl
  import bam_pkg::*;
#(
  parameter int          N    = 8,
  parameter bypassMode_e MODE = BYP_BOTH
) (
  input  logic [N-1:0]  mcand,
  input  logic [N-1:0]  mplier,
  output bypassStrobe_t strobe,
  output logic [N-1:0]  rowZero,
  output logic [N-1:0]  colZero
);

  always_comb begin
    strobe.rowEn = (MODE != BYP_COL);
    strobe.colEn = (MODE != BYP_ROW);
  end

  // Zero detection on each operand bit.
  assign rowZero = ~mplier;
  assign colZero = ~mcand;

endmodule

// File: rtl/bam_add_cell.sv
module bam_add_cell #(
  parameter bit GUARDED = 1'b1
) (
  input  logic ppBit,
  input  logic sumIn,
  input  logic carryIn,
  input  logic zeroKey,
  output logic sumOut,
  output logic carryOut,
  output logic skipped
);

  logic fullSum;
  logic fullCarry;

  assign fullSum   = ppBit ^ sumIn ^ carryIn;
  assign fullCarry = (ppBit & sumIn) | (ppBit & carryIn) | (sumIn & carryIn);

  generate
    if (GUARDED) begin : g_guard
      // A pending carry must never be dropped.
      assign skipped = zeroKey & ~carryIn;
    end else begin : g_plain
      logic unusedCarry;
      assign unusedCarry = carryIn;
      assign skipped = zeroKey;
    end
  endgenerate

  assign sumOut   = skipped ? sumIn : fullSum;
  assign carryOut = skipped ? 1'b0  : fullCarry;

endmodule

// File: rtl/bam_csa_array.sv
module bam_csa_array
  import bam_pkg::*;
#(
  parameter int N = 8,
  localparam int CELLS = N * (N - 1)
) (
  input  logic [N-1:0]     mcand,
  input  logic [N-1:0]     mplier,
  input  bypassStrobe_t    strobe,
  input  logic [N-1:0]     rowZero,
  input  logic [N-1:0]     colZero,
  output logic [N-1:0]     lowBits,
  output logic [N-1:0]     finA,
  output logic [N-1:0]     finB,
  output logic [CELLS-1:0] bypassed
);

  // Flattened per-row sum and carry vectors, index j*N+i.
  logic [N*N-1:0] sumF;
  logic [N*N-1:0] carF;

  // Row 0 is the bare partial-product row.
  generate
    for (genvar i = 0; i < N; i++) begin : g_row0
      assign sumF[i] = mcand[i] & mplier[0];
      assign carF[i] = 1'b0;
    end
  endgenerate

  assign lowBits[0] = sumF[0];

  generate
    for (genvar j = 1; j < N; j++) begin : g_row
      for (genvar i = 0; i < N; i++) begin : g_col
        logic sIn;
        logic key;
        if (i == N - 1) begin : g_top
          assign sIn = carF[(j-1)*N + N - 1];
        end else begin : g_mid
          assign sIn = sumF[(j-1)*N + i + 1];
        end
        assign key = (strobe.rowEn & rowZero[j]) | (strobe.colEn & colZero[i]);
        bam_add_cell #(
          .GUARDED(j > 1)
        ) u_cell (
          .ppBit    (mcand[i] & mplier[j]),
          .sumIn    (sIn),
          .carryIn  (carF[(j-1)*N + i]),
          .zeroKey  (key),
          .sumOut   (sumF[j*N + i]),
          .carryOut (carF[j*N + i]),
          .skipped  (bypassed[(j-1)*N + i])
        );
      end
      assign lowBits[j] = sumF[j*N];
    end
  endgenerate

  // Last row to the carry-propagate stage, aligned to weight N.
  generate
    for (genvar k = 0; k < N; k++) begin : g_fin
      if (k < N - 1) begin : g_a
        assign finA[k] = sumF[(N-1)*N + k + 1];
      end else begin : g_atop
        assign finA[k] = 1'b0;
      end
      assign finB[k] = carF[(N-1)*N + k];
    end
  endgenerate

  logic unusedSum;
  assign unusedSum = sumF[N-1];

endmodule

// File: rtl/bam_final_adder.sv
module bam_final_adder
  import bam_pkg::*;
#(
  parameter int          N     = 8,
  parameter finalAdder_e KIND  = FIN_SELECT,
  parameter int          SEC   = 4,
  localparam int         GROUPS = (N + SEC - 1) / SEC
) (
  input  logic [N-1:0] opA,
  input  logic [N-1:0] opB,
  output logic [N-1:0] sum
);

  generate
    if (KIND == FIN_RIPPLE) begin : g_ripple
      always_comb begin
        logic c;
        c = 1'b0;
        for (int k = 0; k < N; k++) begin
          sum[k] = opA[k] ^ opB[k] ^ c;
          c = (opA[k] & opB[k]) | (c & (opA[k] ^ opB[k]));
        end
      end
    end else if (KIND == FIN_LOOKAHEAD) begin : g_lookahead
      logic [N-1:0] gen;
      logic [N-1:0] prop;
      assign gen  = opA & opB;
      assign prop = opA | opB;
      always_comb begin
        logic cg;
        logic c;
        logic gG;
        logic pG;
        cg = 1'b0;
        sum = '0;
        for (int grp = 0; grp < GROUPS; grp++) begin
          c  = cg;
          gG = 1'b0;
          pG = 1'b1;
          for (int m = grp * SEC; m < (grp + 1) * SEC; m++) begin
            if (m < N) begin
              sum[m] = opA[m] ^ opB[m] ^ c;
              c  = gen[m] | (prop[m] & c);
              gG = gen[m] | (prop[m] & gG);
              pG = pG & prop[m];
            end
          end
          cg = gG | (pG & cg);
        end
      end
    end else begin : g_select
      always_comb begin
        logic cg;
        logic c0;
        logic c1;
        logic [SEC-1:0] s0;
        logic [SEC-1:0] s1;
        cg = 1'b0;
        sum = '0;
        for (int grp = 0; grp < GROUPS; grp++) begin
          c0 = 1'b0;
          c1 = 1'b1;
          s0 = '0;
          s1 = '0;
          for (int m = 0; m < SEC; m++) begin
            if (grp * SEC + m < N) begin
              s0[m] = opA[grp*SEC+m] ^ opB[grp*SEC+m] ^ c0;
              c0 = (opA[grp*SEC+m] & opB[grp*SEC+m]) | (c0 & (opA[grp*SEC+m] ^ opB[grp*SEC+m]));
              s1[m] = opA[grp*SEC+m] ^ opB[grp*SEC+m] ^ c1;
              c1 = (opA[grp*SEC+m] & opB[grp*SEC+m]) | (c1 & (opA[grp*SEC+m] ^ opB[grp*SEC+m]));
            end
          end
          for (int m = 0; m < SEC; m++) begin
            if (grp * SEC + m < N) sum[grp*SEC+m] = cg ? s1[m] : s0[m];
          end
          cg = cg ? c1 : c0;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/bypass_array_mult.sv
module bypass_array_mult
  import bam_pkg::*;
#(
  parameter int          N     = 8,
  parameter bypassMode_e MODE  = BYP_BOTH,
  parameter finalAdder_e FINAL = FIN_SELECT,
  localparam int         CELLS = N * (N - 1)
) (
  input  logic [N-1:0]     mcand,
  input  logic [N-1:0]     mplier,
  output logic [2*N-1:0]   product,
  output logic [CELLS-1:0] bypassMap
);

  bypassStrobe_t strobe;
  logic [N-1:0]  rowZero;
  logic [N-1:0]  colZero;
  logic [N-1:0]  lowBits;
  logic [N-1:0]  finA;
  logic [N-1:0]  finB;
  logic [N-1:0]  highBits;

  bam_bypass_ctrl #(.N(N), .MODE(MODE)) u_ctrl (
    .mcand   (mcand),
    .mplier  (mplier),
    .strobe  (strobe),
    .rowZero (rowZero),
    .colZero (colZero)
  );

  bam_csa_array #(.N(N)) u_array (
    .mcand    (mcand),
    .mplier   (mplier),
    .strobe   (strobe),
    .rowZero  (rowZero),
    .colZero  (colZero),
    .lowBits  (lowBits),
    .finA     (finA),
    .finB     (finB),
    .bypassed (bypassMap)
  );

  bam_final_adder #(.N(N), .KIND(FINAL)) u_final (
    .opA (finA),
    .opB (finB),
    .sum (highBits)
  );

  assign product = {highBits, lowBits};

endmodule

// File: rtl/bam_checker.sv
module bam_checker
  import bam_pkg::*;
#(
  parameter int          N    = 8,
  parameter bypassMode_e MODE = BYP_BOTH,
  localparam int         CELLS = N * (N - 1)
) (
  input logic [N-1:0]     mcand,
  input logic [N-1:0]     mplier,
  input logic [2*N-1:0]   product,
  input logic [CELLS-1:0] bypassMap
);

  logic [2*N-1:0] refProd;
  assign refProd = (2*N)'(mcand) * (2*N)'(mplier);

  always_comb begin
    // R1
    product_exact_chk: assert (product == refProd)
      else $error("product %h vs %h", product, refProd);
    for (int j = 1; j < N; j++) begin
      for (int i = 0; i < N; i++) begin
        if (MODE == BYP_ROW) begin
          // R2
          row_key_chk: assert (!bypassMap[(j-1)*N+i] || !mplier[j])
            else $error("row cell %0d,%0d skipped", j, i);
        end else if (MODE == BYP_COL) begin
          // R3
          col_key_chk: assert (!bypassMap[(j-1)*N+i] || !mcand[i])
            else $error("col cell %0d,%0d skipped", j, i);
        end else begin
          // R4
          both_key_chk: assert (!bypassMap[(j-1)*N+i] || !mcand[i] || !mplier[j])
            else $error("cell %0d,%0d skipped", j, i);
        end
      end
    end
    for (int i = 0; i < N; i++) begin
      // R5
      first_row_chk: assert (bypassMap[i] ==
          (((MODE != BYP_COL) && !mplier[1]) || ((MODE != BYP_ROW) && !mcand[i])))
        else $error("first row cell %0d", i);
    end
    // R6
    zero_mplier_chk: assert (MODE == BYP_COL || mplier != '0 || &bypassMap)
      else $error("zero multiplier map %h", bypassMap);
    // R7
    zero_mcand_chk: assert (MODE == BYP_ROW || mcand != '0 || &bypassMap)
      else $error("zero multiplicand map %h", bypassMap);
    // R8
    ones_chk: assert (!(&mcand && &mplier) || bypassMap == '0)
      else $error("all-ones map %h", bypassMap);
  end

endmodule

bind bypass_array_mult bam_checker #(.N(N), .MODE(MODE)) u_bam_checker (
  .mcand     (mcand),
  .mplier    (mplier),
  .product   (product),
  .bypassMap (bypassMap)
);

// File: tb/bypass_array_mult_bench.sv
`timescale 1ns/1ps
module bypass_array_mult_bench;
  import bam_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [3:0]  a4 = '0, b4 = '0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [15:0] a16 = '0, b16 = '0;

  logic [7:0]   mainProd;
  logic [11:0]  mainStat;
  logic [7:0]   prod4 [9];
  logic [11:0]  stat4 [9];
  logic [15:0]  prod8 [3];
  logic [55:0]  stat8 [3];
  logic [31:0]  prod16 [3];
  logic [239:0] stat16 [3];

  bypass_array_mult #(.N(4), .MODE(BYP_BOTH), .FINAL(FIN_RIPPLE)) u_bypass_array_mult (
    .mcand(a4), .mplier(b4), .product(mainProd), .bypassMap(mainStat));

  generate
    for (genvar g = 0; g < 9; g++) begin : g_n4
      bypass_array_mult #(.N(4), .MODE(bypassMode_e'(g % 3)), .FINAL(finalAdder_e'(g / 3))) u_m (
        .mcand(a4), .mplier(b4), .product(prod4[g]), .bypassMap(stat4[g]));
    end
    for (genvar g = 0; g < 3; g++) begin : g_n8
      bypass_array_mult #(.N(8), .MODE(bypassMode_e'(g)), .FINAL(finalAdder_e'(2 - g))) u_m (
        .mcand(a8), .mplier(b8), .product(prod8[g]), .bypassMap(stat8[g]));
      bypass_array_mult #(.N(16), .MODE(bypassMode_e'(g)), .FINAL(finalAdder_e'(g))) u_w (
        .mcand(a16), .mplier(b16), .product(prod16[g]), .bypassMap(stat16[g]));
    end
  endgenerate

  function automatic string modeTag(int mode);
    if (mode == 0) return "R2";
    if (mode == 1) return "R3";
    return "R4";
  endfunction

  task automatic checkProd(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s product actual %h expected %h", tag, act, exp);
    end
  endtask

  // Map checks derived from R2..R8.
  task automatic checkMap(int n, int mode, logic [15:0] a, logic [15:0] b, logic [255:0] st);
    int bad;
    bit allOnes;
    bit rowK;
    bit colK;
    bit key;
    bad = 0;
    allOnes = ((mode != 1) && b == 0) || ((mode != 0) && a == 0);
    for (int j = 1; j < n; j++) begin
      for (int i = 0; i < n; i++) begin
        rowK = (mode != 1) && !b[j];
        colK = (mode != 0) && !a[i];
        key = rowK || colK;
        if (st[(j-1)*n+i] && !key) begin
          bad++;
          $display("FAIL %s n=%0d cell %0d,%0d actual 1 expected 0", modeTag(mode), n, j, i);
        end
        if (j == 1 && st[i] != key) begin
          bad++;
          $display("FAIL R5 n=%0d cell %0d actual %0b expected %0b", n, i, st[i], key);
        end
        if (allOnes && !st[(j-1)*n+i]) begin
          bad++;
          $display("FAIL %s n=%0d zero operand cell %0d,%0d actual 0 expected 1",
                   (b == 0) ? "R6" : "R7", n, j, i);
        end
      end
    end
    checks++;
    if (bad != 0) failures++;
  endtask

  task automatic run4(logic [3:0] a, logic [3:0] b);
    @(negedge clk);
    a4 = a; b4 = b;
    #1;
    checkProd("R1", {24'd0, mainProd}, 32'(a) * 32'(b));
    checkMap(4, 2, 16'(a), 16'(b), 256'(mainStat));
    for (int g = 0; g < 9; g++) begin
      checkProd("R1", {24'd0, prod4[g]}, 32'(a) * 32'(b));
      checkMap(4, g % 3, 16'(a), 16'(b), 256'(stat4[g]));
    end
  endtask

  task automatic run8(logic [7:0] a, logic [7:0] b);
    @(negedge clk);
    a8 = a; b8 = b;
    #1;
    for (int g = 0; g < 3; g++) begin
      checkProd("R9", {16'd0, prod8[g]}, 32'(a) * 32'(b));
      checkMap(8, g, 16'(a), 16'(b), 256'(stat8[g]));
    end
  endtask

  task automatic run16(logic [15:0] a, logic [15:0] b);
    @(negedge clk);
    a16 = a; b16 = b;
    #1;
    for (int g = 0; g < 3; g++) begin
      checkProd("R9", prod16[g], 32'(a) * 32'(b));
      checkMap(16, g, a, b, 256'(stat16[g]));
    end
  endtask

  initial begin
    #750000;
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Initial operands zero: product 0, every cell skipped (R6, R7).
    #1;
    checks++;
    if (mainProd !== 8'd0 || mainStat !== 12'hfff) begin
      failures++;
      $display("FAIL R6 idle actual %h/%h expected 00/fff", mainProd, mainStat);
    end
    // R8: all-ones operands leave no cell skipped.
    run4(4'hf, 4'hf);
    checks++;
    if (mainStat !== 12'h000) begin
      failures++;
      $display("FAIL R8 actual %h expected 000", mainStat);
    end
    // R1: exhaustive over every mode and final stage at N=4.
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run4(4'(a), 4'(b));
    // R9: exhaustive at N=8.
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        run8(8'(a), 8'(b));
    // R9: corners and walking bits at N=16.
    run16(16'h0000, 16'h0000);
    run16(16'hffff, 16'hffff);
    for (int g = 0; g < 3; g++) begin
      checks++;
      if (stat16[g] !== '0) begin
        failures++;
        $display("FAIL R8 n=16 actual %h expected 0", stat16[g]);
      end
    end
    run16(16'hffff, 16'h0000);
    run16(16'h0000, 16'hffff);
    for (int s = 0; s < 16; s++)
      for (int t = 0; t < 16; t++)
        run16(16'(1) << s, 16'(1) << t);
    for (int k = 0; k < 2000; k++)
      run16(16'($urandom), 16'($urandom));
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule